// File: doc/BRIEF.md
# Hot-Plug Slot Register Set

This block holds the slot registers of a downstream port that supports hot-plug. A simple register bus with a two-bit address, a write strobe and combinational read data gives software three registers. The capabilities register is fixed by parameters and cannot be written. The control register holds the event enables, the indicator codes and the power control bit. The status register latches slot events, clears them when a one is written to a bit, and shows the live interlock, presence and latch levels.

The physical slot inputs (attention button, power fault, latch sensor, presence detect, interlock state) pass through a synchroniser with a parameterised depth, two flops by default. An edge detector turns the synchronised levels into event strobes. A small state machine tracks each control-register write and raises the command-completed flag a fixed number of cycles later. The machine has two states. `CMD_IDLE` moves to `CMD_WAIT` on a control write. `CMD_WAIT` restarts its count on a further write, and once the count reaches its last value it returns to `CMD_IDLE` and strobes completion.

The slot power enable and the two indicator outputs come straight from control-register bits. A one written to the interlock bit gives a one-cycle toggle pulse. The single interrupt output is combinational from the register state.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset the control register reads 0x07C0: all enables 0, both indicators 11 (off), power control 1 (off). slot_pwr_en, irq and emi_toggle are 0, and the status event flags [4:0] read 0.
- R2: Address 0 reads the capabilities word. Bits 0..6 are attention button, power controller, latch sensor, attention indicator, power indicator, surprise removal and hot-plug capable. Bit 17 is interlock present, bit 18 is no-command-completed, and [31:19] is the slot number. The defaults give 0x002A007F. Writes to address 0 have no effect.
- R3: A write to address 1 stores bits [10:0]. From the next cycle attn_ind follows [7:6], pwr_ind follows [9:8] (01 on, 10 blink, 11 off), and slot_pwr_en is the inverse of bit 10.
- R4: A write to address 1 with bit 11 set drives emi_toggle high for exactly the one cycle after the write. Bit 11 always reads 0.
- R5: Each control write sets status bit 4 (command completed) CMD_LAT cycles after the write edge. A new control write inside that window restarts the count. The flag never sets when no-command-completed is reported or when no power controller, indicator or interlock is present.
- R6: The event flags are bit 0 button (rising edge), bit 1 power fault (rising edge), bit 2 latch (either edge) and bit 3 presence (either edge). Each sets one cycle after its synchronised level changes, that is, three clock edges after the input changes.
- R7: A write to address 2 clears each flag in [4:0] whose data bit is 1 and leaves the others unchanged. 0x001F clears all five flags. An event that arrives in the same cycle as its clear leaves the flag set.
- R8: Status bits 5, 6 and 7 show the synchronised latch, presence and interlock levels two edges after the input changes, and writes do not change them.
- R9: irq is 1 exactly when control bit 5 is set and some flag in [4:0] is set whose enable (control bit of the same index) is set.
- R10: The power-fault flag stays set while slot power is off and the fault input stays high, until it is cleared by a write. It sets again only on a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 capabilities, 1 control, 2 status |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| btn_in | input | 1 | Attention button level |
| flt_in | input | 1 | Power fault level |
| mrl_in | input | 1 | Retention latch sensor level |
| prs_in | input | 1 | Card presence level |
| emi_in | input | 1 | Interlock engaged level |
| slot_pwr_en | output | 1 | Slot power enable |
| attn_ind | output | 2 | Attention indicator code |
| pwr_ind | output | 2 | Power indicator code |
| emi_toggle | output | 1 | One-cycle interlock toggle pulse |
| irq | output | 1 | Hot-plug interrupt level |

## Verification
A wrong flag or control bit shows up on irq, on the indicator or power outputs, or in the read data in the cycle after the edge that corrupts it, because all of them are read straight from the registers. A command-completion counter that is off by one shows only when the completion flag appears one edge early or late. So the bench counts the edges from a write to the flag and compares the status register every cycle. A synchroniser or edge detector fault moves the live bits or the event flags by one or more cycles relative to the input, and the every-cycle comparison catches this at the first wrong cycle.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned CTL_W  = 11;
    localparam int unsigned EV_W   = 5;
    localparam int unsigned PIN_W  = 5;

    // synchronised pin vector index
    localparam int unsigned PIN_BTN = 0;
    localparam int unsigned PIN_FLT = 1;
    localparam int unsigned PIN_MRL = 2;
    localparam int unsigned PIN_PRS = 3;
    localparam int unsigned PIN_EMI = 4;

    // status / control bit positions decoded by software
    localparam int unsigned EV_CMD     = 4;
    localparam int unsigned CTL_MASTER = 5;
    localparam int unsigned CTL_PWR    = 10;
    localparam int unsigned CTL_EMI    = 11;

    localparam logic [CTL_W-1:0] CTL_RESET = 11'h7C0;

    typedef enum logic [1:0] {
        SEL_CAP  = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_WAIT = 1'b1
    } cmd_state_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/hp_event_detect.sv
module hp_event_detect import hp_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] lvl,
    output logic [3:0] evt
);
    logic [3:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    always_comb begin
        evt[PIN_BTN] = lvl[PIN_BTN] & ~prev_q[PIN_BTN];
        evt[PIN_FLT] = lvl[PIN_FLT] & ~prev_q[PIN_FLT];
        evt[PIN_MRL] = lvl[PIN_MRL] ^ prev_q[PIN_MRL];
        evt[PIN_PRS] = lvl[PIN_PRS] ^ prev_q[PIN_PRS];
    end
endmodule

// File: rtl/hp_cmd_tracker.sv
module hp_cmd_tracker import hp_pkg::*; #(
    parameter int unsigned CMD_LAT   = 8,
    parameter bit          SUPPORTED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    output logic done,
    output logic busy
);
    localparam int unsigned CW = $clog2(CMD_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(CMD_LAT - 1);

    if (SUPPORTED) begin : g_track
        cmd_state_e    state_q, state_d;
        logic [CW-1:0] cnt_q, cnt_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= CMD_IDLE;
                cnt_q   <= '0;
            end else begin
                state_q <= state_d;
                cnt_q   <= cnt_d;
            end
        end

        always_comb begin
            state_d = state_q;
            cnt_d   = cnt_q;
            unique case (state_q)
                CMD_IDLE: begin
                    if (ctl_wr) begin
                        state_d = CMD_WAIT;
                        cnt_d   = '0;
                    end
                end
                CMD_WAIT: begin
                    if (ctl_wr) begin
                        cnt_d = '0;
                    end else if (cnt_q == LAST) begin
                        state_d = CMD_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = CMD_IDLE;
            endcase
        end

        always_comb begin
            busy = (state_q == CMD_WAIT);
            done = (state_q == CMD_WAIT) && !ctl_wr && (cnt_q == LAST);
        end
    end else begin : g_none
        assign busy = 1'b0;
        assign done = 1'b0;
    end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs import hp_pkg::*; #(
    parameter int unsigned CMD_LAT      = 8,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter logic [12:0] SLOT_NUM     = 13'd5,
    parameter bit          HAS_BTN      = 1'b1,
    parameter bit          HAS_PWR_CTL  = 1'b1,
    parameter bit          HAS_MRL      = 1'b1,
    parameter bit          HAS_ATTN_IND = 1'b1,
    parameter bit          HAS_PWR_IND  = 1'b1,
    parameter bit          SURPRISE_OK  = 1'b1,
    parameter bit          HP_CAPABLE   = 1'b1,
    parameter bit          HAS_EMI      = 1'b1,
    parameter bit          NO_CMD_CPL   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             btn_in,
    input  logic             flt_in,
    input  logic             mrl_in,
    input  logic             prs_in,
    input  logic             emi_in,
    output logic             slot_pwr_en,
    output logic [1:0]       attn_ind,
    output logic [1:0]       pwr_ind,
    output logic             emi_toggle,
    output logic             irq
);
    localparam logic [REG_W-1:0] CAP_VAL = {SLOT_NUM, NO_CMD_CPL, HAS_EMI, 10'd0,
        HP_CAPABLE, SURPRISE_OK, HAS_PWR_IND, HAS_ATTN_IND, HAS_MRL, HAS_PWR_CTL, HAS_BTN};
    localparam bit CPL_OK = !NO_CMD_CPL &&
        (HAS_PWR_CTL || HAS_ATTN_IND || HAS_PWR_IND || HAS_EMI);

    logic [PIN_W-1:0] pins_raw, pins_s;
    logic [3:0]       evt;
    logic [CTL_W-1:0] ctrl_q;
    logic [EV_W-1:0]  flags_q, ev_set, ev_clr;
    logic             wr_ctl, wr_stat, cmd_done, cmd_busy;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:CTL_EMI+1];

    assign pins_raw = {emi_in, prs_in, mrl_in, flt_in, btn_in};
    assign wr_ctl   = reg_wr && (reg_addr == SEL_CTL);
    assign wr_stat  = reg_wr && (reg_addr == SEL_STAT);

    hp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins_raw), .dout(pins_s)
    );

    hp_event_detect u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pins_s[3:0]), .evt(evt)
    );

    hp_cmd_tracker #(.CMD_LAT(CMD_LAT), .SUPPORTED(CPL_OK)) u_cmd (
        .clk(clk), .rst_n(rst_n), .ctl_wr(wr_ctl), .done(cmd_done), .busy(cmd_busy)
    );

    // control register and interlock pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= CTL_RESET;
            emi_toggle <= 1'b0;
        end else begin
            emi_toggle <= wr_ctl && reg_wdata[CTL_EMI] && HAS_EMI;
            if (wr_ctl) ctrl_q <= reg_wdata[CTL_W-1:0];
        end
    end

    // event flags: set beats clear
    assign ev_set = {cmd_done, evt};
    assign ev_clr = wr_stat ? reg_wdata[EV_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~ev_clr) | ev_set;
    end

    // outputs
    always_comb begin
        slot_pwr_en = ~ctrl_q[CTL_PWR];
        attn_ind    = ctrl_q[7:6];
        pwr_ind     = ctrl_q[9:8];
        irq         = ctrl_q[CTL_MASTER] && |(flags_q & ctrl_q[EV_W-1:0]);
    end

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            SEL_CAP:  reg_rdata = CAP_VAL;
            SEL_CTL:  reg_rdata = {{(REG_W-CTL_W){1'b0}}, ctrl_q};
            SEL_STAT: reg_rdata = {{(REG_W-8){1'b0}}, pins_s[PIN_EMI],
                                   pins_s[PIN_PRS], pins_s[PIN_MRL], flags_q};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hp_slot_regs_chk.sv
module hp_slot_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ctl,
    input logic       wr_stat,
    input logic [3:0] wsel,      // {wdata[11], wdata[10], wdata[1], wdata[0]}
    input logic [5:0] ctl_lo,
    input logic [4:0] flags,
    input logic       btn_evt,
    input logic       cmd_busy,
    input logic       slot_pwr_en,
    input logic       emi_toggle,
    input logic       irq
);
    a_r9_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_lo[5] |-> !irq);

    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |(flags & ctl_lo[4:0]));

    a_r4_toggle_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        emi_toggle |-> $past(wr_ctl && wsel[3]));

    a_r3_power_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (slot_pwr_en == !$past(wsel[2])));

    a_r5_cpl_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[4]) |-> $past(cmd_busy));

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr_stat && wsel[1])) |=> flags[1]);

    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wsel[0] && !btn_evt) |=> !flags[0]);
endmodule

bind hp_slot_regs hp_slot_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_stat(wr_stat),
    .wsel({reg_wdata[11], reg_wdata[10], reg_wdata[1], reg_wdata[0]}),
    .ctl_lo(ctrl_q[5:0]), .flags(flags_q), .btn_evt(evt[0]),
    .cmd_busy(cmd_busy), .slot_pwr_en(slot_pwr_en),
    .emi_toggle(emi_toggle), .irq(irq)
);

// File: tb/hp_slot_regs_bench.sv
`timescale 1ns/1ps
module hp_slot_regs_bench;
    localparam int CMD_LAT = 8;
    localparam logic [31:0] CAP_EXP = 32'h002A_007F;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        btn_in = 0, flt_in = 0, mrl_in = 0, prs_in = 0, emi_in = 0;
    logic        slot_pwr_en, emi_toggle, irq;
    logic [1:0]  attn_ind, pwr_ind;

    int n_vec = 0, n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hp_slot_regs u_hp_slot_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .btn_in(btn_in),
        .flt_in(flt_in), .mrl_in(mrl_in), .prs_in(prs_in), .emi_in(emi_in),
        .slot_pwr_en(slot_pwr_en), .attn_ind(attn_ind), .pwr_ind(pwr_ind),
        .emi_toggle(emi_toggle), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [4:0]  d1, d2, d3;          // input delayed by 1, 2, 3 edges
    logic [10:0] m_ctrl;
    logic [4:0]  m_flags;
    logic        m_emi;
    int          m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d1 <= '0; d2 <= '0; d3 <= '0;
            m_ctrl <= 11'h7C0; m_flags <= '0; m_emi <= 0; m_cnt <= 0;
        end else begin : step
            logic [4:0] setv, clrv;
            setv = '0;
            setv[0] = d2[0] && !d3[0];
            setv[1] = d2[1] && !d3[1];
            setv[2] = d2[2] != d3[2];
            setv[3] = d2[3] != d3[3];
            if (reg_wr && reg_addr == 2'd1) begin
                m_cnt  <= CMD_LAT;
                m_ctrl <= reg_wdata[10:0];
            end else if (m_cnt > 0) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) setv[4] = 1'b1;
            end
            m_emi <= reg_wr && reg_addr == 2'd1 && reg_wdata[11];
            clrv = (reg_wr && reg_addr == 2'd2) ? reg_wdata[4:0] : 5'd0;
            m_flags <= (m_flags & ~clrv) | setv;
            d1 <= {emi_in, prs_in, mrl_in, flt_in, btn_in};
            d2 <= d1;
            d3 <= d2;
        end
    end

    function automatic logic [31:0] model_read(logic [1:0] a);
        case (a)
            2'd0:    return CAP_EXP;
            2'd1:    return {21'd0, m_ctrl};
            2'd2:    return {24'd0, d2[4], d2[3], d2[2], m_flags};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        chk("R3 slot_pwr_en", {31'd0, slot_pwr_en}, {31'd0, !m_ctrl[10]});
        chk("R3 attn_ind", {30'd0, attn_ind}, {30'd0, m_ctrl[7:6]});
        chk("R3 pwr_ind", {30'd0, pwr_ind}, {30'd0, m_ctrl[9:8]});
        chk("R4 emi_toggle", {31'd0, emi_toggle}, {31'd0, m_emi});
        chk("R9 irq", {31'd0, irq}, {31'd0, m_ctrl[5] && |(m_flags & m_ctrl[4:0])});
        chk("R7 reg_rdata", reg_rdata, model_read(reg_addr));
    endtask

    task automatic tick();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd1, v); chk("R1 ctrl reset", v, 32'h7C0);
        rd(2'd2, v); chk("R1 flags reset", v & 32'h1F, 32'h0);
        chk("R1 power off", {31'd0, slot_pwr_en}, 32'd0);
        chk("R1 irq low", {31'd0, irq}, 32'd0);

        // R2 capabilities, read-only
        rd(2'd0, v); chk("R2 cap value", v, 32'h002A_007F);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R2 cap ignores write", v, 32'h002A_007F);
        repeat (10) tick();
        wr(2'd2, 32'h1F);                                   // drop completion from nothing

        // R3 indicators and power: attn on(01), pwr blink(10), power on
        wr(2'd1, 32'h0000_027F);
        chk("R3 attn on", {30'd0, attn_ind}, 32'd1);
        chk("R3 pwr blink", {30'd0, pwr_ind}, 32'd2);
        chk("R3 power on", {31'd0, slot_pwr_en}, 32'd1);

        // R5 completion latency
        n = 0;
        for (int i = 0; i < 20; i++) begin
            tick(); n++;
            rd(2'd2, v);
            if (v[4]) break;
        end
        chk("R5 completion latency", n, CMD_LAT);
        chk("R9 irq on completion", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'h10);
        rd(2'd2, v); chk("R7 clear completion", v & 32'h1F, 32'h0);

        // R5 restart by second write
        wr(2'd1, 32'h0000_027F);
        repeat (4) tick();
        wr(2'd1, 32'h0000_027F);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            tick(); n++;
            rd(2'd2, v);
            if (v[4]) break;
        end
        chk("R5 restarted latency", n, CMD_LAT);
        wr(2'd2, 32'h10);

        // R4 interlock toggle pulse
        wr(2'd1, 32'h0000_0A7F);
        chk("R4 toggle high", {31'd0, emi_toggle}, 32'd1);
        rd(2'd1, v); chk("R4 bit 11 reads 0", v, 32'h27F);
        tick();
        chk("R4 toggle one cycle", {31'd0, emi_toggle}, 32'd0);
        repeat (CMD_LAT + 2) tick();
        wr(2'd2, 32'h1F);

        // R6 / R8 presence: live after 2 edges, flag after 3
        prs_in = 1'b1;
        tick(); tick();
        rd(2'd2, v); chk("R8 presence live", {31'd0, v[6]}, 32'd1);
        chk("R6 presence flag not yet", {31'd0, v[3]}, 32'd0);
        tick();
        rd(2'd2, v); chk("R6 presence flag", {31'd0, v[3]}, 32'd1);

        // R6 button: rising sets, falling does not
        btn_in = 1'b1; repeat (4) tick();
        rd(2'd2, v); chk("R6 button press", {31'd0, v[0]}, 32'd1);
        wr(2'd2, 32'h01);
        rd(2'd2, v); chk("R7 partial clear", v & 32'h1F, 32'h08);
        btn_in = 1'b0; repeat (4) tick();
        rd(2'd2, v); chk("R6 button release no flag", {31'd0, v[0]}, 32'd0);

        // R6 latch both edges
        mrl_in = 1'b1; repeat (4) tick();
        wr(2'd2, 32'h04);
        mrl_in = 1'b0; repeat (4) tick();
        rd(2'd2, v); chk("R6 latch falling edge", {31'd0, v[2]}, 32'd1);
        wr(2'd2, 32'h1F);
        rd(2'd2, v); chk("R7 clear all", v & 32'h1F, 32'h0);

        // R7 set wins over clear in the same cycle
        prs_in = 1'b0;
        tick(); tick();
        wr(2'd2, 32'h08);
        rd(2'd2, v); chk("R7 set beats clear", {31'd0, v[3]}, 32'd1);
        wr(2'd2, 32'h1F);

        // R8 live bits ignore writes
        emi_in = 1'b1; mrl_in = 1'b1; prs_in = 1'b1;
        repeat (4) tick();
        wr(2'd2, 32'h1F);
        wr(2'd2, 32'hE0);
        rd(2'd2, v); chk("R8 live bits hold", v, 32'hE0);

        // R9 gating: flags present, master off then partial enable
        wr(2'd1, 32'h0000_07DF);            // enables 0x1F, master off, power off
        repeat (CMD_LAT + 1) tick();
        btn_in = 1'b1; repeat (4) tick();
        chk("R9 master off", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'h0000_07E8);            // master + presence enable only
        tick();
        chk("R9 no enabled flag", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'h0000_07E1);            // master + button enable
        tick();
        chk("R9 enabled flag", {31'd0, irq}, 32'd1);
        repeat (CMD_LAT + 1) tick();
        wr(2'd2, 32'h1F);

        // R10 sticky fault with slot power off
        chk("R10 power off", {31'd0, slot_pwr_en}, 32'd0);
        flt_in = 1'b1;
        repeat (20) tick();
        rd(2'd2, v); chk("R10 fault sticky", {31'd0, v[1]}, 32'd1);
        wr(2'd2, 32'h02);
        repeat (5) tick();
        rd(2'd2, v); chk("R10 no re-set while high", {31'd0, v[1]}, 32'd0);
        flt_in = 1'b0; repeat (4) tick();
        flt_in = 1'b1; repeat (4) tick();
        rd(2'd2, v); chk("R10 new rising edge", {31'd0, v[1]}, 32'd1);

        repeat (5) tick();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule